// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer for a power-management device. Software sets it up through a four-entry register bank. It then has to keep kicking the timer, either by pulsing a feed input or by writing to a feed register. If the kicks stop, the block detects a fault. In window mode it also faults on a kick that comes too soon after the previous one. Elapsed time is measured in ticks of an external 100 µs timebase strobe.

Both limits are coded as exponents. The short limit is 11 ticks (1.1 ms) shifted left by a 3-bit step. The long limit is the short limit shifted left by one more than a 2-bit ratio. When a fault occurs, the block records its cause in a sticky status register. It then drives either a reset output or an interrupt output for a fixed number of ticks, and afterwards starts a new interval.

Top module: `wdog_window`

## Requirements
- R1: After reset all registers read 0, the watchdog is disabled and `rst_o` and `irq_o` are low.
- R2: Register map, selected by `addr`:
  - 0 is control: bits 1:0 enable, bit 2 mode (1 slow-only, 0 window), bit 3 action (1 reset, 0 interrupt).
  - 1 is timing: bits 6:4 step S, bits 1:0 ratio R.
  - 2 is feed: writing 1 to bit 0 kicks; it reads 0.
  - 3 is status: bit 0 early kick, bit 1 timeout.
  - Unimplemented bits read 0.
- R3: The short limit is 11·2^S ticks and the long limit is the short limit times 2^(R+1).
- R4: If the long limit is reached without a kick, the block raises a timeout fault. It does so on the tick that would bring the elapsed count to the long limit.
- R5: In window mode, a kick while the elapsed count is below the short limit is an early fault. A kick at or above the short limit is valid and clears the count.
- R6: In slow-only mode, a kick is valid at any elapsed count.
- R7: The watchdog runs only when the enable field is 01.
  - The values 00, 10 and 11 all leave it disabled, and each reads back as written.
  - While disabled, the count and any pulse are cleared and both outputs stay low, so enabling starts a fresh interval from zero.
- R8: A fault drives `rst_o` if the action bit was 1 at the time of the fault, and `irq_o` otherwise. The two outputs are never high together.
- R9: After a fault the selected output is held for 4 ticks. Kicks and elapsed counting are ignored during the pulse, and counting resumes from zero afterwards.
- R10: Status bits are sticky and are cleared by writing 1 to them. A fault that sets a bit wins over a clear in the same cycle.
- R11: A kick is either a one-cycle `feed_i` pulse or a write of bit 0 = 1 to address 2. The two behave identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase strobe, one per 100 µs |
| feed_i | input | 1 | One-cycle kick strobe |
| wr_en | input | 1 | Register write enable |
| addr | input | 2 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rst_o | output | 1 | Fault pulse, reset action |
| irq_o | output | 1 | Fault pulse, interrupt action |

## Verification
The bench targets the boundary between an early kick and a valid kick in window mode, since a design with an off-by-one compare would fault on a valid kick or let an early one through. It lets the timer run out at two different step/ratio settings; a mistake in the exponent decoding would fire the fault many ticks too soon or too late. It sends kicks during the fault pulse and writes the reserved enable codes. A design that honoured the kicks would shorten the pulse, and one that treated 10 as enabled would raise faults while it should be idle. It clears status bits in the same cycles as other traffic, so a design whose clear was not write-one-to-clear would lose the fault cause.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int BASE_TICKS  = 11,
  parameter int PULSE_TICKS = 4,
  parameter int CW          = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       feed_i,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_o,
  output logic       irq_o
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [3:0]    ctl;
  logic [2:0]    step;
  logic [1:0]    ratio;
  logic [1:0]    sts;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pls;
  logic          act_q;

  wire           run     = ctl[1:0] == 2'b01;
  wire           slow    = ctl[2];
  wire [CW-1:0]  short_t = CW'(BASE_TICKS) << step;
  wire [CW-1:0]  long_t  = short_t << ({1'b0, ratio} + 3'd1);
  wire           kick    = feed_i | (wr_en && addr == 2'd2 && wdata[0]);
  wire           busy    = pls != '0;
  wire           early   = run && !busy && kick && !slow && cnt < short_t;
  wire           late    = run && !busy && !kick && tick &&
                           ({1'b0, cnt} + 1'b1) >= {1'b0, long_t};
  wire [1:0]     clr     = (wr_en && addr == 2'd3) ? wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      step  <= '0;
      ratio <= '0;
      sts   <= '0;
    end else begin
      if (wr_en && addr == 2'd0) ctl <= wdata[3:0];
      if (wr_en && addr == 2'd1) begin
        step  <= wdata[6:4];
        ratio <= wdata[1:0];
      end
      sts <= (sts & ~clr) | {late, early};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pls   <= '0;
      act_q <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      pls <= '0;
    end else if (early || late) begin
      cnt   <= '0;
      pls   <= PW'(PULSE_TICKS);
      act_q <= ctl[3];
    end else if (busy) begin
      if (tick) pls <= pls - 1'b1;
    end else if (kick) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {4'b0, ctl};
      2'd1:    rdata = {1'b0, step, 2'b0, ratio};
      2'd3:    rdata = {6'b0, sts};
      default: rdata = 8'h00;
    endcase
  end

  assign rst_o = busy & act_q;
  assign irq_o = busy & ~act_q;

  p_one_action_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_o && irq_o));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rst_o && !irq_o);

  p_cause_logged_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o || irq_o) |-> sts != 2'b00);

  p_pulse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o || irq_o) && !tick && run && !wr_en |=> $stable({rst_o, irq_o}));

  p_fresh_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o || irq_o) && run |-> cnt == '0);
endmodule

// File: tb/test_wdog_window.sv
`timescale 1ns/1ps
module test_wdog_window;
  logic clk = 0, rst_n = 0, tick = 0, feed_i = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic rst_o, irq_o;

  int vectors = 0, errors = 0, cycles = 0;
  bit tick_en = 0;
  string phase = "R1 reset";

  int m_cnt, m_pls, m_sh, m_lg;
  bit m_act, m_run, m_kick, m_e, m_l;
  bit [3:0] m_ctl;
  bit [2:0] m_s;
  bit [1:0] m_r, m_sts;

  wdog_window i_wdog_window (.clk(clk), .rst_n(rst_n), .tick(tick), .feed_i(feed_i),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_o(rst_o), .irq_o(irq_o));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_pls = 0; m_act = 0; m_ctl = 0; m_s = 0; m_r = 0; m_sts = 0;
    end else begin
      m_run  = m_ctl[1:0] == 2'b01;
      m_sh   = 11 * (1 << m_s);
      m_lg   = m_sh * (1 << (m_r + 1));
      m_kick = feed_i || (wr_en && addr == 2 && wdata[0]);
      m_e = 0; m_l = 0;
      if (!m_run) begin m_cnt = 0; m_pls = 0; end
      else if (m_pls > 0) begin if (tick) m_pls--; end
      else if (m_kick) begin
        if (!m_ctl[2] && m_cnt < m_sh) m_e = 1; else m_cnt = 0;
      end else if (tick) begin
        if (m_cnt + 1 >= m_lg) m_l = 1; else m_cnt++;
      end
      if (m_e || m_l) begin m_cnt = 0; m_pls = 4; m_act = m_ctl[3]; end
      if (wr_en && addr == 3) m_sts &= ~wdata[1:0];
      if (m_e) m_sts[0] = 1;
      if (m_l) m_sts[1] = 1;
      if (wr_en && addr == 0) m_ctl = wdata[3:0];
      if (wr_en && addr == 1) begin m_s = wdata[6:4]; m_r = wdata[1:0]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (rst_o !== (m_pls > 0 && m_act) || irq_o !== (m_pls > 0 && !m_act)) begin
        errors++;
        $display("FAIL %s: rst_o/irq_o=%b%b expected %b%b", phase, rst_o, irq_o,
                 m_pls > 0 && m_act, m_pls > 0 && !m_act);
      end
    end
  end

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick <= tick_en && div == 3;
      div = (div + 1) % 4;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected <150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    vectors++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata[%0d]=%h expected %h", phase, a, rdata, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk); feed_i = 1;
    @(negedge clk); feed_i = 0;
  endtask

  task automatic ticks(input int n);
    repeat (4 * n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1 reset state";
    rd(0, 0); rd(1, 0); rd(2, 0); rd(3, 0);
    tick_en = 1;

    phase = "R2 register readback";
    wr(0, 8'hFF); rd(0, 8'h0F);
    wr(1, 8'hFF); rd(1, 8'h73);
    wr(2, 8'h01); rd(2, 8'h00);

    phase = "R7 reserved enable codes idle";
    ticks(30); rd(3, 0);
    wr(0, 8'h02); rd(0, 8'h02); ticks(30); rd(3, 0);

    phase = "R4 timeout fault with reset action";
    wr(1, 8'h00); wr(0, 8'h0D);
    ticks(24);
    phase = "R9 kicks ignored during pulse";
    kick(); ticks(1); kick();
    ticks(4);
    phase = "R10 timeout cause logged";
    rd(3, 8'h02);
    phase = "R10 write one to clear";
    wr(3, 8'h01); rd(3, 8'h02);
    wr(3, 8'h02); rd(3, 8'h00);
    wr(0, 8'h00);

    phase = "R5 early kick in window mode";
    wr(0, 8'h01); ticks(3); kick(); ticks(1);
    phase = "R8 interrupt action";
    ticks(6); rd(3, 8'h01); wr(3, 8'h03);

    phase = "R5 valid kicks after short limit";
    for (int i = 0; i < 3; i++) begin ticks(15); kick(); end
    rd(3, 8'h00);

    phase = "R6 slow-only mode accepts frequent kicks";
    wr(0, 8'h05);
    for (int i = 0; i < 6; i++) begin ticks(2); kick(); end
    rd(3, 8'h00);

    phase = "R7 disable then fresh interval";
    wr(0, 8'h00); ticks(5); wr(0, 8'h05); ticks(20); rd(3, 8'h00);
    ticks(4); rd(3, 8'h02); wr(3, 8'h02); ticks(6);

    phase = "R3 scaled limits";
    wr(0, 8'h00); wr(1, 8'h12); rd(1, 8'h12); wr(0, 8'h01);
    ticks(20); kick(); ticks(6); rd(3, 8'h01); wr(3, 8'h01);
    phase = "R11 register kick";
    ticks(30); wr(2, 8'h01); rd(3, 8'h00);
    ticks(30); wr(2, 8'h01);
    phase = "R3 scaled timeout";
    ticks(180); rd(3, 8'h02);
    phase = "R8 reset action on scaled timeout";
    wr(0, 8'h09); ticks(180);

    phase = "R7 disable clears outputs";
    wr(0, 8'h00); ticks(3);
    tick_en = 0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule